// File: doc/BRIEF.md
# Byte-align and bit-reverse shuffle unit

This block is the datapath for one class of register shuffle instructions on a 64-bit core. It is purely combinational. It takes two 64-bit source operands, `rs_i` and `rt_i`, the 5-bit shift-amount field of the instruction, and a width select. From these it returns a 64-bit result and a flag that marks an unsupported sub-operation.

Two functions are served, each in a 32-bit and a 64-bit form. The first reverses the bit order inside every byte and keeps each byte in its own lane. The second joins two operands at byte granularity: the high bytes of the result come from `rt_i`, shifted up, and the bytes below them come from the top of `rs_i`. The sub-operation is decoded from the upper bits of the shift-amount field. For the join, the low bits of that field serve as the byte pointer. The 32-bit forms sign-extend their result to 64 bits. Every other field value, including the byte-swap and sign-extend codes of the same class, raises the illegal flag.

Top module: `shuf_unit`

## Requirements
- R1: With `dword_i`=0 and `sa_i`=5'b00000, result bits [31:0] hold each of the four low bytes of `rt_i` with its bits reversed (bit k of a byte moves to bit 7-k), and every byte stays in its own lane.
- R2: Every legal 32-bit operation (`dword_i`=0) drives result bits [63:32] with copies of result bit 31.
- R3: With `dword_i`=1 and `sa_i`=5'b00000, all eight bytes of `rt_i` are bit-reversed in place, with no sign extension.
- R4: With `dword_i`=0 and `sa_i`=5'b010pp, the pointer p=`sa_i[1:0]` selects the result. When p=0 the low 32 bits equal `rt_i[31:0]`. Otherwise they equal (`rt_i[31:0]` << 8p) | (`rs_i[31:0]` >> 8(4-p)), truncated to 32 bits.
- R5: In 32-bit mode, bits [63:32] of `rs_i` and of `rt_i` have no effect on the result.
- R6: With `dword_i`=1 and `sa_i`=5'b01ppp, the pointer p=`sa_i[2:0]` selects the result. When p=0 the result equals `rt_i`. Otherwise it equals (`rt_i` << 8p) | (`rs_i` >> 8(8-p)), truncated to 64 bits.
- R7: Every other `sa_i` value drives `illegal_o`=1. This covers the byte-swap codes (5'b00010, and 5'b00101 in 64-bit mode) and the sign-extend codes (5'b10000, 5'b11000). The legal codes listed in R1, R3, R4 and R6 drive `illegal_o`=0.
- R8: Whenever `illegal_o`=1, `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_i | input | 64 | Source operand that supplies the low-side bytes of the join |
| rt_i | input | 64 | Source operand for the bit reverse and the high side of the join |
| sa_i | input | 5 | Shift-amount field: sub-operation code and byte pointer |
| dword_i | input | 1 | 1 selects the 64-bit forms, 0 selects the 32-bit forms |
| result_o | output | 64 | Shuffled result |
| illegal_o | output | 1 | Unsupported sub-operation; result forced to zero |

## Verification
The bit reverse and the join share one decode field, and so does the width select. A single `sa_i` value can therefore mean two things at once. For example, 5'b01000 is the pointer-zero join in both widths, while 5'b01100 is a join in 64-bit mode but illegal in 32-bit mode. The bench applies the same field values and operands with `dword_i` at both settings. It then checks that each pairing picks the function, pointer and sign extension that the requirements assign to it. The upper operand halves are loaded with patterns that would show in the result if they leaked through in 32-bit mode.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned SA_W   = 5;
  localparam int unsigned PTR_W = $clog2(DATA_W / BYTE_W);

  typedef enum logic [1:0] {
    SOP_BREV  = 2'd0,
    SOP_ALIGN = 2'd1,
    SOP_BAD   = 2'd2
  } sop_e;
endpackage

// File: rtl/shuf_decode.sv
module shuf_decode
  import shuf_pkg::*;
#(
  parameter int unsigned SA_BITS = SA_W,
  parameter int unsigned PW      = PTR_W
) (
  input  logic [SA_BITS-1:0] sa_i,
  input  logic               dword_i,
  output sop_e               sop_o,
  output logic [PW-1:0]      ptr_o
);
  // 32-bit join pointer is one bit narrower than the 64-bit one
  localparam int unsigned WPW = PW - 1;

  always_comb begin
    sop_o = SOP_BAD;
    ptr_o = '0;
    if (sa_i == '0) begin
      sop_o = SOP_BREV;
    end else if (dword_i) begin
      if (sa_i[SA_BITS-1:PW] == 'b01) begin
        sop_o = SOP_ALIGN;
        ptr_o = sa_i[PW-1:0];
      end
    end else begin
      if (sa_i[SA_BITS-1:WPW] == 'b010) begin
        sop_o = SOP_ALIGN;
        ptr_o = {1'b0, sa_i[WPW-1:0]};
      end
    end
  end
endmodule

// File: rtl/shuf_brev.sv
module shuf_brev #(
  parameter int unsigned W  = 64,
  parameter int unsigned BW = 8
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned NB = W / BW;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar k = 0; k < BW; k++) begin : g_bit
      assign q_o[b*BW + k] = d_i[b*BW + (BW-1-k)];
    end
  end
endmodule

// File: rtl/shuf_align.sv
module shuf_align #(
  parameter int unsigned W  = 64,
  parameter int unsigned BW = 8,
  parameter int unsigned PW = 3
) (
  input  logic [W-1:0]  rs_i,
  input  logic [W-1:0]  rt_i,
  input  logic [PW-1:0] ptr_i,
  input  logic          dword_i,
  output logic [W-1:0]  q_o
);
  localparam int unsigned HW = W / 2;

  logic [2*W-1:0] cat_d;
  logic [W-1:0]   cat_w;
  logic [2*W-1:0] sh_d;
  logic [W-1:0]   sh_w;

  // funnel: upper half of {rt,rs} shifted up by whole bytes; ptr 0 leaves rt
  always_comb begin
    cat_d = {rt_i, rs_i};
    cat_w = {rt_i[HW-1:0], rs_i[HW-1:0]};
    sh_d  = cat_d << (ptr_i * BW);
    sh_w  = cat_w << (ptr_i * BW);
    if (dword_i) q_o = sh_d[2*W-1:W];
    else         q_o = {{HW{1'b0}}, sh_w[W-1:HW]};
  end
endmodule

// File: rtl/shuf_unit.sv
module shuf_unit
  import shuf_pkg::*;
(
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [SA_W-1:0]   sa_i,
  input  logic              dword_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  localparam int unsigned HW = DATA_W / 2;

  sop_e              sop;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] brev_q;
  logic [DATA_W-1:0] align_q;
  logic [DATA_W-1:0] raw;

  shuf_decode #(.SA_BITS(SA_W), .PW(PTR_W)) u_dec (
    .sa_i(sa_i), .dword_i(dword_i), .sop_o(sop), .ptr_o(ptr)
  );

  shuf_brev #(.W(DATA_W), .BW(BYTE_W)) u_brev (
    .d_i(rt_i), .q_o(brev_q)
  );

  shuf_align #(.W(DATA_W), .BW(BYTE_W), .PW(PTR_W)) u_align (
    .rs_i(rs_i), .rt_i(rt_i), .ptr_i(ptr), .dword_i(dword_i), .q_o(align_q)
  );

  always_comb begin
    unique case (sop)
      SOP_BREV:  raw = brev_q;
      SOP_ALIGN: raw = align_q;
      default:   raw = '0;
    endcase
    if (!dword_i) raw = {{HW{raw[HW-1]}}, raw[HW-1:0]};
    illegal_o = (sop == SOP_BAD);
    result_o  = illegal_o ? '0 : raw;
  end
endmodule

// File: rtl/shuf_unit_chk.sv
module shuf_unit_chk
  import shuf_pkg::*;
(
  input logic [DATA_W-1:0] rs_i,
  input logic [DATA_W-1:0] rt_i,
  input logic [SA_W-1:0]   sa_i,
  input logic              dword_i,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  localparam int unsigned HW = DATA_W / 2;

  always_comb begin
    if (!$isunknown({rs_i, rt_i, sa_i, dword_i, result_o, illegal_o})) begin
      p_illegal_zero_r8: assert (!illegal_o || result_o == '0);
      p_word_sext_r2: assert (dword_i || illegal_o ||
                              result_o[DATA_W-1:HW] == {HW{result_o[HW-1]}});
      p_byteswap_bad_r7: assert (sa_i != 5'b00010 || illegal_o);
      p_sext_code_bad_r7: assert ((sa_i != 5'b10000 && sa_i != 5'b11000) || illegal_o);
      p_brev_legal_r1: assert (sa_i != '0 || !illegal_o);
      p_walign_zero_r4: assert (dword_i || sa_i != 5'b01000 ||
                                result_o[HW-1:0] == rt_i[HW-1:0]);
      p_dalign_zero_r6: assert (!dword_i || sa_i != 5'b01000 || result_o == rt_i);
    end
  end
endmodule

bind shuf_unit shuf_unit_chk u_chk (.*);

// File: tb/sim_shuf_unit.sv
`timescale 1ns/1ps
module sim_shuf_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] rs, rt, res;
  logic [4:0]  sa;
  logic        dw, ill;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  shuf_unit u0 (
    .rs_i(rs), .rt_i(rt), .sa_i(sa), .dword_i(dw),
    .result_o(res), .illegal_o(ill)
  );

  function automatic logic [63:0] ref_brev(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++)
      for (int k = 0; k < 8; k++)
        r[b*8+k] = v[b*8+7-k];
    return r;
  endfunction

  function automatic logic [63:0] sext32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] ref_walign(input logic [63:0] a, input logic [63:0] t,
                                             input int p);
    logic [31:0] hi, lo;
    if (p == 0) return sext32(t[31:0]);
    hi = t[31:0] << (8*p);
    lo = a[31:0] >> (8*(4-p));
    return sext32(hi | lo);
  endfunction

  function automatic logic [63:0] ref_dalign(input logic [63:0] a, input logic [63:0] t,
                                             input int p);
    if (p == 0) return t;
    return (t << (8*p)) | (a >> (8*(8-p)));
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] t,
                       input logic [4:0] s, input logic d);
    @(negedge clk);
    rs = a; rt = t; sa = s; dw = d;
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] exp_r, input logic exp_i);
    n_run++;
    if (res !== exp_r || ill !== exp_i) begin
      n_fail++;
      $display("FAIL %s: sa=%b dw=%0b got res=%h ill=%0b exp res=%h ill=%0b",
               req, sa, dw, res, ill, exp_r, exp_i);
    end
  endtask

  task automatic t_reset;
    apply('0, '0, '0, 1'b0);
    check("R1 reset", 64'h0, 1'b0);
  endtask

  task automatic t_word_brev;
    logic [63:0] v[3] = '{64'h0000_0000_0102_0480, 64'hDEAD_BEEF_1234_5678,
                          64'h0000_0000_8000_0001};
    foreach (v[i]) begin
      apply(64'hFFFF_FFFF_FFFF_FFFF, v[i], 5'b00000, 1'b0);
      check("R1 R2 word brev", sext32(ref_brev(v[i])[31:0]), 1'b0);
    end
  endtask

  task automatic t_dword_brev;
    apply('0, 64'h0102_0408_1020_4080, 5'b00000, 1'b1);
    check("R3 dword brev", 64'h8040_2010_0804_0201, 1'b0);
    apply('0, 64'h0123_4567_89AB_CDEF, 5'b00000, 1'b1);
    check("R3 dword brev", ref_brev(64'h0123_4567_89AB_CDEF), 1'b0);
  endtask

  task automatic t_word_align;
    for (int p = 0; p < 4; p++) begin
      apply(64'hA5A5_A5A5_1122_3344, 64'h5A5A_5A5A_8899_AABB, {3'b010, p[1:0]}, 1'b0);
      check("R4 R2 word align", ref_walign(64'h1122_3344, 64'h8899_AABB, p), 1'b0);
    end
  endtask

  task automatic t_word_upper_ignored;
    apply(64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0011, 5'b01011, 1'b0);
    check("R5 upper rs ignored", 64'h0000_0000_1100_0000, 1'b0);
    apply(64'h0, 64'hFFFF_FFFF_0000_0001, 5'b00000, 1'b0);
    check("R5 upper rt ignored", 64'h0000_0000_0000_0080, 1'b0);
  endtask

  task automatic t_dword_align;
    for (int p = 0; p < 8; p++) begin
      apply(64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, {2'b01, p[2:0]}, 1'b1);
      check("R6 dword align",
            ref_dalign(64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, p), 1'b0);
    end
  endtask

  task automatic t_illegal;
    logic [4:0] codes[5] = '{5'b00010, 5'b10000, 5'b11000, 5'b00101, 5'b11111};
    foreach (codes[i]) begin
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, codes[i], 1'b0);
      check("R7 R8 word illegal", 64'h0, 1'b1);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, codes[i], 1'b1);
      check("R7 R8 dword illegal", 64'h0, 1'b1);
    end
    // 01100 is a join only in 64-bit mode
    apply(64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 5'b01100, 1'b0);
    check("R7 word 01100 illegal", 64'h0, 1'b1);
    apply(64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 5'b01100, 1'b1);
    check("R6 dword 01100 legal",
          ref_dalign(64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 4), 1'b0);
  endtask

  initial begin
    rs = '0; rt = '0; sa = '0; dw = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_word_brev();
    t_dword_brev();
    t_word_align();
    t_word_upper_ignored();
    t_dword_align();
    t_illegal();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule